// File: doc/BRIEF.md
# Decimating Spectrum and AGC Line Capture

This block builds one display line of 128 bits and then passes it on to a circulating display memory. It divides a slow reference tick down to a scan trigger once per second. After each trigger it takes in one serial spectrum scan of 200 points and keeps only every second point. It then takes in a run of AGC level bits. Each kept bit goes into one of two 64-cell buffers, and successive bits alternate between the even bank and the odd bank.

When the line is full the block raises a ready flag and holds the line. The line is held until a load strobe arrives from the line-counter comparison logic. The block then streams the line out as 64 pairs, one even-bank bit and one odd-bank bit on each clock. After that it goes idle and waits for the next trigger. The reference divide, scan length, decimation factor, AGC field length and bank depth are all parameters. Their combined sizes are checked when the design is elaborated.

Top module: `lc_line_capture`

## Requirements
- R1: `scan_trig` is a one-cycle pulse. It fires on the clock after every REF_DIV-th sampled `ref_tick` (default 1500). The ticks are counted from reset and the count runs freely.
- R2: A capture starts only when `scan_trig` is seen while the block is idle. A `din_vld` that arrives while the block is idle is ignored.
- R3: Point indices count from 0 in the order the strobes arrive. Of the 200 strobed points in a scan, indices 0, 2, 4, … 198 are kept and the odd-indexed points are dropped.
- R4: Kept bits are numbered k in order. Kept bit k goes to the even bank when k is even and to the odd bank when k is odd, at cell floor(k/2).
- R5: After the 200th point, the next 28 strobed bits are AGC bits. They take kept numbers k = 100 to 127 and follow the placement rule of R4.
- R6: `line_rdy` is low until the 28th AGC bit is sampled. It reads high on the following clock.
- R7: While `line_rdy` is high, `din_vld` and `scan_trig` have no effect, and the held line is unchanged.
- R8: A `load_stb` sampled while the line is ready starts the burst. `burst_vld` is high for exactly 64 consecutive cycles, starting two clock edges after the strobe is sampled. In burst cycle i, `burst_even` carries even cell i and `burst_odd` carries odd cell i, with i rising from 0.
- R9: `line_rdy` falls in the same cycle that the last pair is presented. The block then waits for the next trigger.
- R10: A `load_stb` sampled while `line_rdy` is low causes no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| din | input | 1 | Serial spectrum or AGC bit |
| din_vld | input | 1 | Strobe qualifying `din` |
| load_stb | input | 1 | Line-match strobe that releases the burst |
| scan_trig | output | 1 | Once-per-REF_DIV-ticks scan start pulse |
| line_rdy | output | 1 | Full line held, or burst in progress |
| burst_vld | output | 1 | Burst pair valid |
| burst_even | output | 1 | Even-bank bit of the current pair |
| burst_odd | output | 1 | Odd-bank bit of the current pair |

## Verification
Nearly every internal fault shows up in the 64 burst pairs of the next line. Phase or counter faults do so within one line time. A decimation phase off by one changes every spectrum pair. A swapped bank select exchanges `burst_even` and `burst_odd`. A point counter off by one shifts the boundary between spectrum and AGC by one cell. A divider fault shows up as a wrong tick count between two `scan_trig` pulses, at the first trigger after reset. A state machine that leaves the ready state early or late shows up as a wrong `line_rdy` edge: at the 28th AGC bit, or at the last burst pair.

// File: rtl/lc_pkg.sv
package lc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SPEC,
      ST_AGC,
      ST_READY,
      ST_BURST
   } lc_state_e;
endpackage

// File: rtl/lc_trig_gen.sv
module lc_trig_gen #(
   parameter int REF_DIV = 1500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   output logic trig
);
   localparam int RW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
   localparam logic [RW-1:0] LAST = RW'(REF_DIV - 1);

   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         trig  <= 1'b0;
      end else begin
         trig <= 1'b0;
         if (ref_tick) begin
            if (cnt_q == LAST) begin
               cnt_q <= '0;
               trig  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lc_decim.sv
module lc_decim #(
   parameter int DECIM = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic keep
);
   generate
      if (DECIM == 1) begin : g_pass
         assign keep = 1'b1;
      end else begin : g_phase
         localparam int PHW = $clog2(DECIM);
         localparam logic [PHW-1:0] PH_LAST = PHW'(DECIM - 1);
         logic [PHW-1:0] phase_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               phase_q <= '0;
            end else if (adv) begin
               phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            end
         end
         assign keep = (phase_q == '0);
      end
   endgenerate
endmodule

// File: rtl/lc_dual_buf.sv
module lc_dual_buf #(
   parameter int DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     wr_odd,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic                     wr_bit,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic                     rd_even,
   output logic                     rd_odd
);
   genvar b;
   generate
      for (b = 0; b < 2; b++) begin : g_bank
         logic [DEPTH-1:0] cells;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cells <= '0;
            end else if (wr_en && (wr_odd == 1'(b))) begin
               cells[wr_addr] <= wr_bit;
            end
         end
      end
   endgenerate

   assign rd_even = g_bank[0].cells[rd_addr];
   assign rd_odd  = g_bank[1].cells[rd_addr];
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
   import lc_pkg::*;
#(
   parameter int SCAN_PTS = 200,
   parameter int DEPTH    = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     trig,
   input  logic                     din_vld,
   input  logic                     load_stb,
   input  logic                     keep,
   output lc_state_e                state,
   output logic                     wr_en,
   output logic                     wr_odd,
   output logic [$clog2(DEPTH)-1:0] wr_addr,
   output logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic                     dec_clr,
   output logic                     dec_adv
);
   localparam int LINE_BITS = 2 * DEPTH;
   localparam int KW = $clog2(LINE_BITS);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = $clog2(SCAN_PTS);
   localparam logic [PW-1:0] PT_LAST = PW'(SCAN_PTS - 1);
   localparam logic [KW-1:0] K_LAST  = KW'(LINE_BITS - 1);
   localparam logic [AW-1:0] B_LAST  = AW'(DEPTH - 1);

   logic [PW-1:0] pt_q;
   logic [KW-1:0] k_q;
   logic [AW-1:0] bidx_q;

   assign wr_en   = din_vld && (((state == ST_SPEC) && keep) || (state == ST_AGC));
   assign wr_odd  = k_q[0];
   assign wr_addr = k_q[KW-1:1];
   assign rd_addr = bidx_q;
   assign dec_clr = (state == ST_IDLE);
   assign dec_adv = (state == ST_SPEC) && din_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pt_q   <= '0;
         k_q    <= '0;
         bidx_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (trig) begin
               state <= ST_SPEC;
               pt_q  <= '0;
               k_q   <= '0;
            end
            ST_SPEC: if (din_vld) begin
               if (keep) k_q <= k_q + 1'b1;
               if (pt_q == PT_LAST) state <= ST_AGC;
               else                 pt_q  <= pt_q + 1'b1;
            end
            ST_AGC: if (din_vld) begin
               k_q <= k_q + 1'b1;
               if (k_q == K_LAST) state <= ST_READY;
            end
            ST_READY: if (load_stb) begin
               state  <= ST_BURST;
               bidx_q <= '0;
            end
            ST_BURST: begin
               bidx_q <= bidx_q + 1'b1;
               if (bidx_q == B_LAST) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lc_line_capture.sv
module lc_line_capture
   import lc_pkg::*;
#(
   parameter int REF_DIV  = 1500,
   parameter int SCAN_PTS = 200,
   parameter int DECIM    = 2,
   parameter int AGC_BITS = 28,
   parameter int DEPTH    = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   input  logic din,
   input  logic din_vld,
   input  logic load_stb,
   output logic scan_trig,
   output logic line_rdy,
   output logic burst_vld,
   output logic burst_even,
   output logic burst_odd
);
   localparam int AW = $clog2(DEPTH);
   localparam int KEPT = SCAN_PTS / DECIM;

   generate
      if (DECIM < 1 || (SCAN_PTS % DECIM) != 0) begin : g_bad_decim
         $error("SCAN_PTS must be a multiple of DECIM");
      end
      if (KEPT + AGC_BITS != 2 * DEPTH || AGC_BITS < 1) begin : g_bad_line
         $error("kept points plus AGC bits must fill both banks");
      end
      if (DEPTH < 2 || REF_DIV < 2 || SCAN_PTS < 2) begin : g_bad_size
         $error("DEPTH, REF_DIV and SCAN_PTS must be at least 2");
      end
   endgenerate

   lc_state_e         state;
   logic              keep, wr_en, wr_odd, dec_clr, dec_adv;
   logic              rd_even, rd_odd;
   logic [AW-1:0]     wr_addr, rd_addr;

   lc_trig_gen #(.REF_DIV(REF_DIV)) u_trig (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .trig(scan_trig)
   );

   lc_decim #(.DECIM(DECIM)) u_decim (
      .clk(clk), .rst_n(rst_n), .clr(dec_clr), .adv(dec_adv), .keep(keep)
   );

   lc_ctrl #(.SCAN_PTS(SCAN_PTS), .DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .trig(scan_trig), .din_vld(din_vld),
      .load_stb(load_stb), .keep(keep), .state(state), .wr_en(wr_en),
      .wr_odd(wr_odd), .wr_addr(wr_addr), .rd_addr(rd_addr),
      .dec_clr(dec_clr), .dec_adv(dec_adv)
   );

   lc_dual_buf #(.DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_odd(wr_odd),
      .wr_addr(wr_addr), .wr_bit(din), .rd_addr(rd_addr),
      .rd_even(rd_even), .rd_odd(rd_odd)
   );

   assign line_rdy = (state == ST_READY) || (state == ST_BURST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_vld  <= 1'b0;
         burst_even <= 1'b0;
         burst_odd  <= 1'b0;
      end else begin
         burst_vld  <= (state == ST_BURST);
         burst_even <= (state == ST_BURST) ? rd_even : 1'b0;
         burst_odd  <= (state == ST_BURST) ? rd_odd  : 1'b0;
      end
   end
endmodule

// File: rtl/lc_line_capture_chk.sv
module lc_line_capture_chk #(
   parameter int REF_DIV = 1500,
   parameter int DEPTH   = 64
) (
   input logic clk,
   input logic rst_n,
   input logic ref_tick,
   input logic load_stb,
   input logic scan_trig,
   input logic line_rdy,
   input logic burst_vld
);
   localparam int TW = $clog2(REF_DIV + 1);
   localparam int RW = $clog2(DEPTH + 1);

   logic [TW-1:0] tick_seen;
   logic [RW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_seen <= '0;
         run_len   <= '0;
      end else begin
         if (scan_trig)     tick_seen <= ref_tick ? TW'(1) : '0;
         else if (ref_tick) tick_seen <= tick_seen + 1'b1;
         run_len <= burst_vld ? run_len + 1'b1 : '0;
      end
   end

   a_r1_trig_period: assert property (@(posedge clk) disable iff (!rst_n)
      scan_trig |-> tick_seen == TW'(REF_DIV));
   a_r1_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      scan_trig |=> !scan_trig);
   a_r6_rdy_rise_idle_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_rdy) |-> !burst_vld);
   a_r7_rdy_held: assert property (@(posedge clk) disable iff (!rst_n)
      (line_rdy && !burst_vld && !load_stb) |=> line_rdy);
   a_r8_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      burst_vld |-> run_len < RW'(DEPTH));
   a_r8_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_vld && $past(burst_vld)) |-> run_len == RW'(DEPTH));
   a_r8_burst_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_vld) |-> line_rdy);
   a_r9_rdy_fall_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_rdy) |-> burst_vld);
   a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && !line_rdy) |=> !burst_vld);
endmodule

bind lc_line_capture lc_line_capture_chk #(.REF_DIV(REF_DIV), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .load_stb(load_stb),
   .scan_trig(scan_trig), .line_rdy(line_rdy), .burst_vld(burst_vld)
);

// File: tb/lc_line_capture_bench.sv
module lc_line_capture_bench;
   localparam int REF_DIV = 1500;
   localparam int NPTS    = 200;
   localparam int NKEEP   = 100;
   localparam int NAGC    = 28;
   localparam int DEPTH   = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_tick = 1'b0;
   logic din = 1'b0;
   logic din_vld = 1'b0;
   logic load_stb = 1'b0;
   logic scan_trig, line_rdy, burst_vld, burst_even, burst_odd;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lc_line_capture u_lc_line_capture (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .din(din),
      .din_vld(din_vld), .load_stb(load_stb), .scan_trig(scan_trig),
      .line_rdy(line_rdy), .burst_vld(burst_vld),
      .burst_even(burst_even), .burst_odd(burst_odd)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit pt_bit(input int s, input int p);
      return ((p * 7 + s * 11 + (p / 3) * (s + 1)) % 5) < 2;
   endfunction

   function automatic bit agc_bit(input int s, input int j);
      return ((j * 3 + s * 5) % 7) < 3;
   endfunction

   // kept bit k: spectrum point 2k for k < 100, else AGC bit k-100
   function automatic bit kept_bit(input int s, input int k);
      return (k < NKEEP) ? pt_bit(s, 2 * k) : agc_bit(s, k - NKEEP);
   endfunction

   // R1 monitor: counts the ticks it drives between observed triggers
   initial begin
      int tick_cnt = 0;
      int ntrig = 0;
      int ph = 0;
      bit prev_trig = 1'b0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (ref_tick) tick_cnt++;
         if (scan_trig) begin
            ntrig++;
            if (ntrig <= 4) chk(tick_cnt == REF_DIV, "R1 ticks between triggers", tick_cnt, REF_DIV);
            chk(!prev_trig, "R1 one-cycle pulse", int'(prev_trig), 0);
            tick_cnt = 0;
         end
         prev_trig = scan_trig;
         ph++;
         ref_tick = (ph % 3) != 0;
      end
   end

   task automatic wait_trig();
      do @(negedge clk); while (!scan_trig);
   endtask

   task automatic run_line(input int s);
      wait_trig();
      @(negedge clk);
      for (int p = 0; p < NPTS; p++) begin
         din = pt_bit(s, p);
         din_vld = 1'b1;
         load_stb = (p == 50);
         @(negedge clk);
         load_stb = 1'b0;
         if (p == 52) chk(!burst_vld, "R10 early load ignored", int'(burst_vld), 0);
         if (p % 9 == 4) begin
            din_vld = 1'b0;
            din = ~din;
            @(negedge clk);
         end
      end
      for (int j = 0; j < NAGC; j++) begin
         din = agc_bit(s, j);
         din_vld = 1'b1;
         @(negedge clk);
         if (j == NAGC - 2) chk(!line_rdy, "R6 not ready before last AGC bit", int'(line_rdy), 0);
         if (j == NAGC - 1) chk(line_rdy, "R6 ready after last AGC bit", int'(line_rdy), 1);
      end
      // R7: extra strobes while ready must not touch the line
      for (int q = 0; q < 12; q++) begin
         din = (q % 2) == 0;
         din_vld = 1'b1;
         @(negedge clk);
      end
      din_vld = 1'b0;
      if (s == 1) begin
         wait_trig();
         repeat (3) @(negedge clk);
      end
      chk(line_rdy, "R7 ready held", int'(line_rdy), 1);
      load_stb = 1'b1;
      @(negedge clk);
      load_stb = 1'b0;
      chk(!burst_vld, "R8 burst latency", int'(burst_vld), 0);
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) begin
         chk(burst_vld, "R8 burst valid", int'(burst_vld), 1);
         chk(burst_even == kept_bit(s, 2 * i), "R3 R4 R5 even pair bit",
             int'(burst_even), int'(kept_bit(s, 2 * i)));
         chk(burst_odd == kept_bit(s, 2 * i + 1), "R3 R4 R5 odd pair bit",
             int'(burst_odd), int'(kept_bit(s, 2 * i + 1)));
         if (i == 0) chk(line_rdy, "R9 ready during burst", int'(line_rdy), 1);
         if (i == DEPTH - 1) chk(!line_rdy, "R9 ready clears on last pair", int'(line_rdy), 0);
         else @(negedge clk);
      end
      @(negedge clk);
      chk(!burst_vld, "R8 burst length", int'(burst_vld), 0);
      // R2: strobes while idle are ignored
      for (int q = 0; q < 20; q++) begin
         din = 1'b1;
         din_vld = (q % 3) != 1;
         load_stb = (q == 5);
         @(negedge clk);
      end
      din_vld = 1'b0;
      load_stb = 1'b0;
      chk(!line_rdy, "R2 idle strobes start nothing", int'(line_rdy), 0);
      chk(!burst_vld, "R10 idle load ignored", int'(burst_vld), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!scan_trig, "R1 reset trigger low", int'(scan_trig), 0);
      chk(!line_rdy, "R6 reset not ready", int'(line_rdy), 0);
      chk(!burst_vld, "R8 reset no burst", int'(burst_vld), 0);
      rst_n = 1'b1;
      for (int q = 0; q < 30; q++) begin
         din = (q % 2) == 0;
         din_vld = 1'b1;
         @(negedge clk);
      end
      din_vld = 1'b0;
      for (int s = 0; s < 4; s++) run_line(s);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule